// File: doc/BRIEF.md
# Armed Edge-Triggered Glitch Pulse Timer

This block times a fault-injection pulse. It drives the gate of a crowbar transistor that briefly shorts a supply rail. A host sets two values over a serial link: the delay from trigger to pulse, and the pulse length, both counted in glitch-clock cycles. The host then arms the block. While the block is disarmed the trigger pin is ignored, so other logic can toggle that pin freely without causing a glitch.

Once armed, the next level change on the asynchronous trigger pin starts the sequence. Either a rising or a falling edge counts. The block counts the programmed delay, holds the crowbar output high for the programmed number of cycles, and then disarms itself and reports completion to the host. At a 37 MHz glitch clock one step is about 27 ns. The full 16-bit range covers delays such as 240 to 250 cycles and widths such as 59 cycles, each reproduced to the exact cycle.

Top module: `glitch_timer`

## Requirements
- R1: After reset the crowbar output is low, the serial output is high (line idle), and the status reads idle.
- R2: While the status is idle, changes on the trigger input produce no pulse and leave the status at idle.
- R3: While armed, a rising edge and a falling edge on the trigger input each start the sequence.
- R4: With a programmed delay of N, the crowbar output is first high at clock edge N+3, where edge 1 is the first clock edge that samples the changed trigger level. The 3 covers two synchronizer flops and the edge register.
- R5: The crowbar output stays high for exactly the programmed width W in cycles. A width of 0 gives no pulse.
- R6: When the sequence ends, including one with width 0, the block returns to idle and sends 0x47 ('G'). A further trigger edge then produces no pulse.
- R7: Commands are bytes. 0x4F ('O') followed by a high byte and a low byte sets the delay. 0x57 ('W') followed by a high byte and a low byte sets the width. 0x41 ('A') arms the block. 0x44 ('D') disarms it. Each accepted command is answered with 0x4B ('K'), and any other command byte is answered with 0x3F ('?').
- R8: An arm command received while the status is not idle is answered with '?' and leaves the status unchanged.
- R9: A 'D' received while a sequence is running aborts it. The crowbar output drops, the status returns to idle, and no 'G' is sent.
- R10: A delay or width write received while a sequence is running is answered with 'K'. The running sequence keeps its old values, and the new values apply from the next arm.
- R11: The 2-bit status output encodes idle=0, armed=1, waiting=2, pulsing=3.
- R12: The serial link is 8N1, least significant bit first, with one bit lasting CLKS_PER_BIT clock cycles (by default the clock rate divided by 115200).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Glitch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_rx_i | input | 1 | Serial command input from host |
| uart_tx_o | output | 1 | Serial reply output to host |
| trig_i | input | 1 | Asynchronous trigger pin |
| crowbar_o | output | 1 | Crowbar gate drive, high during the pulse |
| status_o | output | 2 | Sequencer status: idle, armed, waiting or pulsing |

## Verification
The bench measures the delay from the trigger change to the first high crowbar sample in whole cycles, and the number of high samples. A design that miscounted the synchronizer stages or the reload value would be off by one in either number. Width 0 and delay 0 are tested directly; a design that wrapped its counter would instead produce a pulse 65536 cycles long. The bench toggles the trigger while disarmed and again after a sequence has completed, which exposes a design that fails to disarm. A width rewrite during a delay must leave the running pulse unchanged and take effect on the next one. A 'D' sent mid-pulse must drop the output immediately and suppress the completion byte.

// File: rtl/glitch_pkg.sv
package glitch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PULSE = 2'd3
  } gstate_e;

  localparam logic [7:0] CMD_OFF   = 8'h4F;
  localparam logic [7:0] CMD_WID   = 8'h57;
  localparam logic [7:0] CMD_ARM   = 8'h41;
  localparam logic [7:0] CMD_DIS   = 8'h44;
  localparam logic [7:0] RSP_OK    = 8'h4B;
  localparam logic [7:0] RSP_BAD   = 8'h3F;
  localparam logic [7:0] RSP_DONE  = 8'h47;
endpackage

// File: rtl/glitch_uart_rx.sv
module glitch_uart_rx #(
  parameter int CPB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  localparam int CW = $clog2(CPB + 1);

  logic          r1, r2, busy;
  logic [CW-1:0] ph;
  logic [3:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r1 <= 1'b1; r2 <= 1'b1; busy <= 1'b0; ph <= '0;
      bitn <= '0; sh <= '0; data_o <= '0; valid_o <= 1'b0;
    end else begin
      r1 <= rx_i;
      r2 <= r1;
      valid_o <= 1'b0;
      if (!busy) begin
        if (!r2) begin
          busy <= 1'b1;
          ph   <= CW'(CPB / 2);
          bitn <= '0;
        end
      end else if (ph != '0) begin
        ph <= ph - 1'b1;
      end else begin
        ph   <= CW'(CPB - 1);
        bitn <= bitn + 1'b1;
        if (bitn == 4'd0) begin
          if (r2) busy <= 1'b0;
        end else if (bitn <= 4'd8) begin
          sh <= {r2, sh[7:1]};
        end else begin
          busy <= 1'b0;
          if (r2) begin
            valid_o <= 1'b1;
            data_o  <= sh;
          end
        end
      end
    end
  end

  a_r12_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
endmodule

// File: rtl/glitch_uart_tx.sv
module glitch_uart_tx #(
  parameter int CPB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       tx_o
);
  localparam int CW = $clog2(CPB + 1);

  logic          busy;
  logic [9:0]    fr;
  logic [3:0]    n;
  logic [CW-1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; fr <= '1; n <= '0; ph <= '0;
    end else if (!busy) begin
      if (valid_i) begin
        fr   <= {1'b1, data_i, 1'b0};
        busy <= 1'b1;
        n    <= '0;
        ph   <= CW'(CPB - 1);
      end
    end else if (ph != '0) begin
      ph <= ph - 1'b1;
    end else begin
      ph <= CW'(CPB - 1);
      fr <= {1'b1, fr[9:1]};
      n  <= n + 1'b1;
      if (n == 4'd9) busy <= 1'b0;
    end
  end

  assign ready_o = !busy;
  assign tx_o    = busy ? fr[0] : 1'b1;
endmodule

// File: rtl/glitch_cmd.sv
module glitch_cmd
  import glitch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  input  gstate_e          state_i,
  input  logic             done_i,
  output logic             arm_o,
  output logic             abort_o,
  output logic [CNT_W-1:0] off_o,
  output logic [CNT_W-1:0] wid_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i
);
  typedef enum logic [1:0] {P_CMD, P_HI, P_LO} pstate_e;

  pstate_e    ps;
  logic       is_w, rp, gp;
  logic [7:0] hi, rbyte;
  logic       tx_go;

  assign tx_valid_o = rp || gp;
  assign tx_data_o  = rp ? rbyte : RSP_DONE;
  assign tx_go      = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps <= P_CMD; is_w <= 1'b0; rp <= 1'b0; gp <= 1'b0;
      hi <= '0; rbyte <= '0; arm_o <= 1'b0; abort_o <= 1'b0;
      off_o <= '0; wid_o <= '0;
    end else begin
      arm_o   <= 1'b0;
      abort_o <= 1'b0;
      if (tx_go) begin
        if (rp) rp <= 1'b0;
        else    gp <= 1'b0;
      end
      if (done_i) gp <= 1'b1;
      if (rx_valid_i) begin
        case (ps)
          P_CMD: begin
            rp <= 1'b1;
            rbyte <= RSP_OK;
            case (rx_data_i)
              CMD_OFF: begin ps <= P_HI; is_w <= 1'b0; rp <= 1'b0; end
              CMD_WID: begin ps <= P_HI; is_w <= 1'b1; rp <= 1'b0; end
              CMD_ARM: begin
                if (state_i == ST_IDLE) arm_o <= 1'b1;
                else rbyte <= RSP_BAD;
              end
              CMD_DIS: abort_o <= 1'b1;
              default: rbyte <= RSP_BAD;
            endcase
          end
          P_HI: begin hi <= rx_data_i; ps <= P_LO; end
          default: begin
            if (is_w) wid_o <= CNT_W'({hi, rx_data_i});
            else      off_o <= CNT_W'({hi, rx_data_i});
            rp <= 1'b1;
            rbyte <= RSP_OK;
            ps <= P_CMD;
          end
        endcase
      end
    end
  end

  a_r8_arm_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |-> state_i == ST_IDLE);
endmodule

// File: rtl/glitch_seq.sv
module glitch_seq
  import glitch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             arm_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic [CNT_W-1:0] wid_i,
  output gstate_e          state_o,
  output logic             crowbar_o,
  output logic             done_o
);
  logic             t1, t2, t3, edge_seen;
  logic [CNT_W-1:0] cnt, off_a, wid_a;

  assign edge_seen = t2 ^ t3;
  assign crowbar_o = (state_o == ST_PULSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1 <= 1'b0; t2 <= 1'b0; t3 <= 1'b0;
      state_o <= ST_IDLE; cnt <= '0; off_a <= '0; wid_a <= '0; done_o <= 1'b0;
    end else begin
      t1 <= trig_i;
      t2 <= t1;
      t3 <= t2;
      done_o <= 1'b0;
      if (abort_i) begin
        state_o <= ST_IDLE;
      end else begin
        case (state_o)
          ST_IDLE: if (arm_i) begin
            state_o <= ST_ARMED;
            off_a <= off_i;
            wid_a <= wid_i;
          end
          ST_ARMED: if (edge_seen) begin
            if (off_a != '0) begin
              state_o <= ST_WAIT; cnt <= off_a - 1'b1;
            end else if (wid_a != '0) begin
              state_o <= ST_PULSE; cnt <= wid_a - 1'b1;
            end else begin
              state_o <= ST_IDLE; done_o <= 1'b1;
            end
          end
          ST_WAIT: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (wid_a != '0) begin
              state_o <= ST_PULSE; cnt <= wid_a - 1'b1;
            end else begin
              state_o <= ST_IDLE; done_o <= 1'b1;
            end
          end
          default: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin state_o <= ST_IDLE; done_o <= 1'b1; end
          end
        endcase
      end
    end
  end

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && !arm_i) |=> state_o == ST_IDLE);
  a_r5_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_PULSE && cnt != '0 && !abort_i) |=> crowbar_o);
  a_r6_auto_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_PULSE && cnt == '0 && !abort_i) |=> (state_o == ST_IDLE && done_o));
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (state_o == ST_IDLE && !crowbar_o && !done_o));
endmodule

// File: rtl/glitch_timer.sv
module glitch_timer
  import glitch_pkg::*;
#(
  parameter int CLK_HZ       = 37_000_000,
  parameter int BAUD         = 115_200,
  parameter int CLKS_PER_BIT = CLK_HZ / BAUD,
  parameter int CNT_W        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uart_rx_i,
  output logic       uart_tx_o,
  input  logic       trig_i,
  output logic       crowbar_o,
  output logic [1:0] status_o
);
  logic [7:0]       rx_data, tx_data;
  logic             rx_valid, tx_valid, tx_ready;
  logic             arm, abort, done;
  logic [CNT_W-1:0] off, wid;
  gstate_e          st;

  assign status_o = st;

  glitch_uart_rx #(.CPB(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(uart_rx_i),
    .data_o(rx_data), .valid_o(rx_valid));

  glitch_uart_tx #(.CPB(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .data_i(tx_data), .valid_i(tx_valid),
    .ready_o(tx_ready), .tx_o(uart_tx_o));

  glitch_cmd #(.CNT_W(CNT_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .state_i(st), .done_i(done), .arm_o(arm), .abort_o(abort),
    .off_o(off), .wid_o(wid), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready));

  glitch_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .arm_i(arm), .abort_i(abort),
    .off_i(off), .wid_i(wid), .state_o(st), .crowbar_o(crowbar_o),
    .done_o(done));
endmodule

// File: tb/sim_glitch_timer.sv
module sim_glitch_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 16;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, trig = 1'b0;
  logic tx, crowbar;
  logic [1:0] status;
  int errors = 0, checks = 0;
  int cyc = 0;
  logic [7:0] q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  glitch_timer #(.CLKS_PER_BIT(CPB)) u0 (
    .clk(clk), .rst_n(rst_n), .uart_rx_i(rx), .uart_tx_o(tx),
    .trig_i(trig), .crowbar_o(crowbar), .status_o(status));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, act=%0d exp=<180000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // reply capture
  always begin
    logic [7:0] b;
    @(negedge tx);
    repeat (CPB / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(negedge clk);
      b[i] = tx;
    end
    repeat (CPB) @(negedge clk);
    q.push_back(b);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic expect_reply(input logic [7:0] e, input string tag);
    int t = 0;
    while (q.size() == 0 && t < CPB * 30) begin
      @(negedge clk);
      t++;
    end
    if (q.size() == 0) chk(1'b0, tag, -1, e);
    else begin
      logic [7:0] g = q.pop_front();
      chk(g == e, tag, g, e);
    end
  endtask

  task automatic prog(input int off, input int wid);
    send_byte(8'h4F); send_byte(8'(off >> 8)); send_byte(8'(off));
    expect_reply(8'h4B, "R7 delay write ack");
    send_byte(8'h57); send_byte(8'(wid >> 8)); send_byte(8'(wid));
    expect_reply(8'h4B, "R7 width write ack");
  endtask

  task automatic arm_it();
    send_byte(8'h41);
    expect_reply(8'h4B, "R7 arm ack");
    repeat (3) @(negedge clk);
    chk(status == 2'd1, "R11 armed status", status, 1);
  endtask

  function automatic int exp_first(input int off, input int wid);
    return (wid == 0) ? 0 : off + 3;
  endfunction

  // toggle trigger and measure the pulse
  task automatic fire(input int off, input int wid, input string tag);
    int first = 0, hi = 0;
    bit saw_wait = 0;
    @(negedge clk);
    trig = ~trig;
    for (int i = 1; i <= off + wid + 12; i++) begin
      @(negedge clk);
      if (status == 2'd2) saw_wait = 1;
      if (crowbar) begin
        hi++;
        if (first == 0) first = i;
      end
    end
    chk(first == exp_first(off, wid), {tag, " R4 pulse start"}, first, exp_first(off, wid));
    chk(hi == wid, {tag, " R5 pulse width"}, hi, wid);
    if (off > 0) chk(saw_wait, {tag, " R11 waiting status"}, saw_wait, 1);
    expect_reply(8'h47, {tag, " R6 done byte"});
    chk(status == 2'd0, {tag, " R6 back to idle"}, status, 0);
  endtask

  task automatic no_pulse(input int n, input string tag);
    int hi = 0;
    @(negedge clk);
    trig = ~trig;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (crowbar || status != 2'd0) hi++;
    end
    chk(hi == 0, tag, hi, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(crowbar == 1'b0, "R1 crowbar low after reset", crowbar, 0);
    chk(tx == 1'b1, "R1 serial idle high", tx, 1);
    chk(status == 2'd0, "R1 R11 idle status", status, 0);

    for (int k = 0; k < 3; k++) no_pulse(20, "R2 trigger ignored while idle");

    prog(240, 59); arm_it(); fire(240, 59, "directed 240/59");
    no_pulse(40, "R6 edge after completion ignored");
    prog(250, 59); arm_it(); fire(250, 59, "directed 250/59 R3");
    prog(0, 1);    arm_it(); fire(0, 1, "directed zero delay");
    prog(5, 0);    arm_it(); fire(5, 0, "directed zero width");

    for (int k = 0; k < 6; k++) begin
      int o = $urandom_range(0, 40);
      int w = $urandom_range(1, 20);
      prog(o, w); arm_it(); fire(o, w, "random R3");
    end

    send_byte(8'h5A);
    expect_reply(8'h3F, "R7 unknown command");

    prog(7, 3); arm_it();
    send_byte(8'h41);
    expect_reply(8'h3F, "R8 arm while armed");
    chk(status == 2'd1, "R8 status unchanged", status, 1);
    fire(7, 3, "after rearm attempt");

    begin
      int hi = 0;
      prog(1500, 5); arm_it();
      @(negedge clk); trig = ~trig;
      send_byte(8'h57); send_byte(8'h00); send_byte(8'h09);
      expect_reply(8'h4B, "R10 write during sequence ack");
      for (int i = 0; i < 1200; i++) begin
        @(negedge clk);
        if (crowbar) hi++;
      end
      chk(hi == 5, "R10 running pulse keeps old width", hi, 5);
      expect_reply(8'h47, "R10 done byte");
      arm_it(); fire(1500, 9, "R10 next arm uses new width");
    end

    prog(0, 4000); arm_it();
    @(negedge clk); trig = ~trig;
    repeat (10) @(negedge clk);
    chk(crowbar == 1'b1, "R9 pulse running before abort", crowbar, 1);
    send_byte(8'h44);
    expect_reply(8'h4B, "R9 abort ack");
    chk(crowbar == 1'b0, "R9 crowbar dropped", crowbar, 0);
    chk(status == 2'd0, "R9 idle after abort", status, 0);
    repeat (CPB * 20) @(negedge clk);
    chk(q.size() == 0, "R9 no done byte after abort", q.size(), 0);
    no_pulse(30, "R9 R2 trigger ignored after abort");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule